// File: doc/BRIEF.md
# Interrupt Pin Edge/Level Detector

This block watches a set of active-low external interrupt pins and turns them into per-pin pending flags for a processor core. Each pin first passes through a synchronizer. The first sampling flop captures on the falling clock phase by default. One more delay flop follows, so the block always has a current synchronized sample and the sample from one cycle earlier.

A single mode bit sets how all pins are treated.

- **Level mode:** a synchronized low pin sets its flag on every cycle it stays low.
- **Edge mode:** only a high-to-low transition between the delayed and current samples produces a one-cycle set pulse.

Reset leaves the mode bit at 0, so low pins are seen as level requests while boot code runs. Software must write the bit to 1 to get edge behaviour.

Software removes flags through a write-one-to-clear port. A hardware set and a software clear that hit the same flag in the same cycle resolve in favour of the set. A pending output reports whether any flag is raised.

Top module: `irq_pin_detect`

## Requirements
- R1: While reset is applied and right after it is released, every bit of `irq_flags` is 0, `irq_pending` is 0 and the detector is in level mode.
- R2: In level mode, a pin driven low is first reflected in `irq_flags` after the second rising clock edge that follows the change. After the first rising edge the flag is still 0.
- R3: In level mode, a flag keeps being set for as long as its pin stays low, so a clear issued during that time leaves the flag at 1.
- R4: In edge mode (`cfg_edge_en` written as 1), a high-to-low pin transition sets its flag exactly once. A clear issued while the pin stays low leaves the flag at 0.
- R5: In edge mode, a low-to-high pin transition does not set the flag.
- R6: In edge mode, a low phase of two cycles followed by a high phase of two cycles and another low phase is detected as two separate transitions.
- R7: With `clr_we` high, each bit set to 1 in `clr_mask` clears the matching flag at the next rising edge. Bits set to 0 leave their flags unchanged.
- R8: The mode bit takes the value of `cfg_edge_en` at the rising edge where `cfg_we` is high. Value 1 selects edge mode and value 0 selects level mode.
- R9: `irq_pending` is 1 exactly when at least one bit of `irq_flags` is 1.
- R10: Each pin `irq_pin_n[i]` affects only flag bit i.
- R11: When a set and a clear hit the same flag in the same cycle, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | NUM_PINS | Active-low interrupt pins, asynchronous to clk |
| cfg_we | input | 1 | Write strobe for the mode bit |
| cfg_edge_en | input | 1 | New mode bit: 1 selects edge mode, 0 selects level mode |
| clr_we | input | 1 | Write strobe for the clear mask |
| clr_mask | input | NUM_PINS | Write-one-to-clear mask for the flags |
| irq_flags | output | NUM_PINS | Per-pin interrupt flags |
| irq_pending | output | 1 | High while any flag is set |

## Verification
The bench holds a pin low across the release of reset to confirm that the block starts in level mode. A design that came out of reset in edge mode would miss this boot-time request.

Several cases target the set-versus-clear conflict:
- A clear during a held-low level request must be overridden.
- A clear during a held-low edge request must stick.
- A clear that arrives in the same cycle as a fresh falling edge must lose.

A design that gave the clear priority, or that kept re-firing in edge mode, fails one of these cases.

Further cases cover other corner behaviour:
- The bench issues the shortest guaranteed low/high/low pattern to catch a delay line that merges two transitions.
- It checks the first-edge latency to catch a synchronizer with a stage missing.
- It uses partial clear masks to catch a clear that spills onto neighbouring flags.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic {
      DET_LEVEL = 1'b0,
      DET_EDGE  = 1'b1
   } det_mode_e;

   // Set request for one pin from its current and one-cycle-older samples.
   function automatic logic set_request(det_mode_e mode, logic now_lvl, logic old_lvl);
      if (mode == DET_EDGE) return old_lvl & ~now_lvl;
      return ~now_lvl;
   endfunction

endpackage

// File: rtl/irq_sync_line.sv
module irq_sync_line #(
   parameter int SYNC_STAGES    = 2,
   parameter bit SAMPLE_ON_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic sync_lvl,
   output logic sync_old
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("irq_sync_line: SYNC_STAGES must be at least 2");
   end

   logic            first_q;
   logic [LAST:1]   rest_q;
   logic            old_q;

   if (SAMPLE_ON_FALL) begin : g_fall_sample
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) first_q <= 1'b1;
         else        first_q <= pin_n;
      end
   end else begin : g_rise_sample
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) first_q <= 1'b1;
         else        first_q <= pin_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rest_q <= '1;
         old_q  <= 1'b1;
      end else begin
         rest_q[1] <= first_q;
         for (int k = 2; k <= LAST; k++) rest_q[k] <= rest_q[k-1];
         old_q <= rest_q[LAST];
      end
   end

   assign sync_lvl = rest_q[LAST];
   assign sync_old = old_q;
endmodule

// File: rtl/irq_set_decode.sv
module irq_set_decode
   import irq_pkg::*;
(
   input  det_mode_e mode,
   input  logic      sync_lvl,
   input  logic      sync_old,
   output logic      set_req
);
   always_comb begin
      set_req = set_request(mode, sync_lvl, sync_old);
   end
endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_val,
   output logic edge_on
);
   logic edge_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     edge_q <= 1'b0;
      else if (wr_en) edge_q <= wr_val;
   end

   assign edge_on = edge_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] flags
);
   logic [WIDTH-1:0] flags_q;
   logic [WIDTH-1:0] clr_vec;

   assign clr_vec = clr_we ? clr_mask : '0;

   // A set in the same cycle as a clear keeps the flag high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= set_vec | (flags_q & ~clr_vec);
   end

   assign flags = flags_q;
endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect
   import irq_pkg::*;
#(
   parameter int NUM_PINS       = 4,
   parameter int SYNC_STAGES    = 2,
   parameter bit SAMPLE_ON_FALL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_pin_n,
   input  logic                cfg_we,
   input  logic                cfg_edge_en,
   input  logic                clr_we,
   input  logic [NUM_PINS-1:0] clr_mask,
   output logic [NUM_PINS-1:0] irq_flags,
   output logic                irq_pending
);
   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("irq_pin_detect: NUM_PINS must lie in 1..32");
   end

   logic                edge_on;
   det_mode_e           mode;
   logic [NUM_PINS-1:0] sync_lvl;
   logic [NUM_PINS-1:0] sync_old;
   logic [NUM_PINS-1:0] set_pulse;

   irq_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_val  (cfg_edge_en),
      .edge_on (edge_on)
   );

   assign mode = edge_on ? DET_EDGE : DET_LEVEL;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      irq_sync_line #(
         .SYNC_STAGES    (SYNC_STAGES),
         .SAMPLE_ON_FALL (SAMPLE_ON_FALL)
      ) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_n    (irq_pin_n[i]),
         .sync_lvl (sync_lvl[i]),
         .sync_old (sync_old[i])
      );

      irq_set_decode u_dec (
         .mode     (mode),
         .sync_lvl (sync_lvl[i]),
         .sync_old (sync_old[i]),
         .set_req  (set_pulse[i])
      );
   end

   irq_flag_bank #(.WIDTH(NUM_PINS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_pulse),
      .clr_we   (clr_we),
      .clr_mask (clr_mask),
      .flags    (irq_flags)
   );

   assign irq_pending = |irq_flags;
endmodule

// File: rtl/irq_pin_detect_chk.sv
module irq_pin_detect_chk #(
   parameter int NUM_PINS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                edge_mode,
   input logic                cfg_we,
   input logic                cfg_edge_en,
   input logic                clr_we,
   input logic [NUM_PINS-1:0] clr_mask,
   input logic [NUM_PINS-1:0] sync_lvl,
   input logic [NUM_PINS-1:0] set_pulse,
   input logic [NUM_PINS-1:0] irq_flags
);
   p_mode_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (edge_mode == $past(cfg_edge_en)));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
         set_pulse[i] |=> irq_flags[i]);

      p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && clr_mask[i] && !set_pulse[i]) |=> !irq_flags[i]);

      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_pulse[i] && !(clr_we && clr_mask[i])) |=> $stable(irq_flags[i]));

      p_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!edge_mode && !sync_lvl[i]) |=> irq_flags[i]);

      p_edge_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_mode && set_pulse[i]) ##1 edge_mode |-> !set_pulse[i]);
   end
endmodule

bind irq_pin_detect irq_pin_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .edge_mode   (edge_on),
   .cfg_we      (cfg_we),
   .cfg_edge_en (cfg_edge_en),
   .clr_we      (clr_we),
   .clr_mask    (clr_mask),
   .sync_lvl    (sync_lvl),
   .set_pulse   (set_pulse),
   .irq_flags   (irq_flags)
);

// File: tb/irq_pin_detect_tb_top.sv
`timescale 1ns/1ps
module irq_pin_detect_tb_top;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_pin_n = 4'b1110;
   logic         cfg_we = 1'b0;
   logic         cfg_edge_en = 1'b0;
   logic         clr_we = 1'b0;
   logic [N-1:0] clr_mask = '0;
   logic [N-1:0] irq_flags;
   logic         irq_pending;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_pin_detect #(.NUM_PINS(N)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_pin_n   (irq_pin_n),
      .cfg_we      (cfg_we),
      .cfg_edge_en (cfg_edge_en),
      .clr_we      (clr_we),
      .clr_mask    (clr_mask),
      .irq_flags   (irq_flags),
      .irq_pending (irq_pending)
   );

   // All driving and sampling happens 2 ns after a rising edge.
   task automatic step(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_flags(logic [N-1:0] m);
      clr_we = 1'b1;
      clr_mask = m;
      step();
      clr_we = 1'b0;
      clr_mask = '0;
   endtask

   task automatic write_mode(logic e);
      cfg_we = 1'b1;
      cfg_edge_en = e;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic t_reset_boot();
      step(3);
      check("R1 flags in reset", irq_flags, 4'b0000);
      check("R1 pending in reset", irq_pending, 1'b0);
      rst_n = 1'b1;
      step();
      check("R1 flags after release", irq_flags, 4'b0000);
      step();
      check("R8 level mode at boot sees low pin0", irq_flags, 4'b0001);
      irq_pin_n = 4'b1111;
      step(3);
      clear_flags(4'b0001);
      check("R1 flags cleared after boot", irq_flags, 4'b0000);
   endtask

   task automatic t_level();
      irq_pin_n = 4'b1011;
      step();
      check("R2 no flag after first edge", irq_flags, 4'b0000);
      step();
      check("R2 flag after second edge", irq_flags, 4'b0100);
      check("R9 pending with a flag", irq_pending, 1'b1);
      clear_flags(4'b0100);
      check("R3 clear loses to held-low level pin", irq_flags, 4'b0100);
      irq_pin_n = 4'b1111;
      step(3);
      clear_flags(4'b0100);
      check("R7 level flag cleared once pin high", irq_flags, 4'b0000);
      check("R9 pending with no flag", irq_pending, 1'b0);
   endtask

   task automatic t_edge();
      write_mode(1'b1);
      irq_pin_n = 4'b1101;
      step(2);
      check("R4 falling edge sets flag", irq_flags, 4'b0010);
      clear_flags(4'b0010);
      step(3);
      check("R4 no re-set while held low", irq_flags, 4'b0000);
      irq_pin_n = 4'b1111;
      step(4);
      check("R5 rising edge sets nothing", irq_flags, 4'b0000);
      // Two-cycle low, two-cycle high, then low again.
      irq_pin_n = 4'b1101;
      step(2);
      check("R6 first short low detected", irq_flags, 4'b0010);
      irq_pin_n = 4'b1111;
      clear_flags(4'b0010);
      check("R6 flag cleared between lows", irq_flags, 4'b0000);
      step();
      irq_pin_n = 4'b1101;
      step(2);
      check("R6 second low after two-cycle high detected", irq_flags, 4'b0010);
      irq_pin_n = 4'b1111;
      step(3);
      clear_flags(4'b0010);
   endtask

   task automatic t_set_wins();
      irq_pin_n = 4'b1110;
      step(2);
      check("R11 setup flag0 raised", irq_flags, 4'b0001);
      irq_pin_n = 4'b1111;
      step(3);
      irq_pin_n = 4'b1110;
      step();
      // The set pulse is active during this cycle; the clear collides with it.
      clear_flags(4'b0001);
      check("R11 set beats simultaneous clear", irq_flags, 4'b0001);
      irq_pin_n = 4'b1111;
      step(3);
      clear_flags(4'b0001);
      check("R7 flag0 cleared", irq_flags, 4'b0000);
   endtask

   task automatic t_mask_and_mode();
      write_mode(1'b0);
      irq_pin_n = 4'b0110;
      step(2);
      check("R10 only pins 0 and 3 flagged", irq_flags, 4'b1001);
      irq_pin_n = 4'b1111;
      step(3);
      clear_flags(4'b0001);
      check("R7 partial clear leaves bit3", irq_flags, 4'b1000);
      check("R9 pending with bit3", irq_pending, 1'b1);
      clear_flags(4'b1000);
      check("R7 second clear empties", irq_flags, 4'b0000);
      // Back in level mode, a held-low pin re-sets after a clear (R8).
      irq_pin_n = 4'b1110;
      step(3);
      clear_flags(4'b0001);
      check("R8 level mode restored by write of 0", irq_flags, 4'b0001);
      irq_pin_n = 4'b1111;
      step(3);
      clear_flags(4'b0001);
   endtask

   initial begin
      step();
      t_reset_boot();
      t_level();
      t_edge();
      t_set_wins();
      t_mask_and_mode();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule